// File: doc/BRIEF.md
# Rotating Priority Resolver with In-Service Tracking

This block arbitrates among eight interrupt request lines. It forms a candidate set from the pending lines that are not masked. It ranks that set against a 3-bit rotation offset, then compares the best candidate with the best line already in service. The interrupt output rises only when the candidate ranks strictly higher. The block holds the in-service register and the rotation offset. Its interrupt output and selected line are combinational functions of those registers and the current inputs, so they are recomputed every cycle.

A one-cycle acknowledge strobe grants the line being requested. It either records that line in service or, when automatic end-of-interrupt is enabled, retires it at once. Retiring can optionally rotate priority so that the serviced line ranks lowest. A command strobe with a 3-bit opcode carries the end-of-interrupt and priority commands. These cover the non-specific and specific forms, their rotating variants, and a direct set-priority. A nesting option, meant for a primary controller with a cascaded secondary on line 2, leaves line 2's in-service bit out of the comparison. This lets further requests from the secondary get through.

Commands are decoded by an enumerated opcode: `OP_NOP`, `OP_EOI`, `OP_EOI_AT`, `OP_EOI_ROT`, `OP_EOI_AT_ROT` and `OP_SET_BASE`. The next-state process moves in-service and offset by one of these transitions each cycle: grant, auto-retire, retire-highest, retire-named, rotate, or hold.

Top module: `rpr_ctrl`

## Requirements
- R1: After reset the in-service register is 0, the offset is 0, `irq_out` is low and `irq_line` is 7.
- R2: Priority index p stands for line (p + offset) mod 8, and index 0 ranks highest. The candidate set is `req_pend & ~req_mask`, and its best-ranked line is the one offered.
- R3: `irq_out` is high only when the candidate set is non-empty and its best index is strictly smaller than the best index of the in-service set, where an empty set counts as 8. When `irq_out` is high, `irq_line` is the candidate line; otherwise it is 7.
- R4: `ack` while `irq_out` is high sets the in-service bit of `irq_line` (with `auto_eoi` low). `ack` while `irq_out` is low changes neither in-service nor offset.
- R5: With `auto_eoi` high, a granted `ack` leaves the in-service register unchanged. If `auto_rot` is also high, the offset becomes (line + 1) mod 8.
- R6: Opcode 1 clears the in-service bit of the best-ranked in-service line. Opcode 3 does the same and also sets the offset to (that line + 1) mod 8. With nothing in service, neither opcode has any effect.
- R7: Opcode 2 clears the in-service bit of `cmd_line`. Opcode 4 does the same and also sets the offset to (`cmd_line` + 1) mod 8.
- R8: Opcode 5 sets the offset to (`cmd_line` + 1) mod 8 and leaves the in-service register unchanged.
- R9: With `nest_special` high, in-service bit 2 is left out of the R3 comparison. It is still cleared normally by opcode 1.
- R10: A command that arrives in the same cycle as `ack` is ignored. Opcodes 0, 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_pend | input | 8 | Pending request lines |
| req_mask | input | 8 | Mask, 1 blocks a line |
| ack | input | 1 | Acknowledge strobe |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode (R6-R8, R10) |
| cmd_line | input | 3 | Line or value operand of a command |
| auto_eoi | input | 1 | Retire granted line on acknowledge |
| auto_rot | input | 1 | Rotate on automatic retire |
| nest_special | input | 1 | Exclude in-service bit 2 from comparison |
| irq_out | output | 1 | Interrupt request |
| irq_line | output | 3 | Selected line, 7 when none |
| in_service | output | 8 | In-service register |
| rot_ofs | output | 3 | Rotation offset |

## Verification
The assertions watch, on every cycle, that the offered line is always pending and unmasked, and that 7 is reported whenever nothing is requested. They also check that a grant without automatic retire leaves its bit in service, and that the state holds still when no strobe arrives. Only the bench scenarios can show the ranking under a rotated offset, the choice of which bit a non-specific retire clears, the nesting exclusion, and the precedence of acknowledge over a same-cycle command. A randomized run against a reference model covers the combinations.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
    typedef enum logic [2:0] {
        OP_NOP        = 3'd0,
        OP_EOI        = 3'd1,
        OP_EOI_AT     = 3'd2,
        OP_EOI_ROT    = 3'd3,
        OP_EOI_AT_ROT = 3'd4,
        OP_SET_BASE   = 3'd5
    } op_e;
endpackage

// File: rtl/rpr_rank.sv
module rpr_rank #(
    parameter int LINES = 8,
    localparam int W = $clog2(LINES)
) (
    input  logic [LINES-1:0] vec,
    input  logic [W-1:0]     ofs,
    output logic [W:0]       rank,
    output logic [W-1:0]     line
);
    logic [W-1:0] cand_l;

    // Scan from the lowest rank upward; the last hit written is the best.
    always_comb begin
        rank   = (W+1)'(LINES);
        line   = '0;
        cand_l = '0;
        for (int p = LINES - 1; p >= 0; p--) begin
            cand_l = W'(p) + ofs;
            if (vec[cand_l]) begin
                rank = (W+1)'(p);
                line = cand_l;
            end
        end
    end
endmodule

// File: rtl/rpr_state.sv
module rpr_state
    import rpr_pkg::*;
#(
    parameter int LINES = 8,
    localparam int W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    input  logic             grant,
    input  logic [W-1:0]     grant_line,
    input  logic             auto_eoi,
    input  logic             auto_rot,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [W-1:0]     cmd_line,
    input  logic             top_found,
    input  logic [W-1:0]     top_line,
    output logic [LINES-1:0] isr_q,
    output logic [W-1:0]     ofs_q
);
    logic [LINES-1:0] isr_d;
    logic [W-1:0]     ofs_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
            ofs_q <= '0;
        end else begin
            isr_q <= isr_d;
            ofs_q <= ofs_d;
        end
    end

    always_comb begin
        isr_d = isr_q;
        ofs_d = ofs_q;
        if (ack) begin
            if (grant) begin
                if (!auto_eoi)
                    isr_d[grant_line] = 1'b1;
                else if (auto_rot)
                    ofs_d = grant_line + W'(1);
            end
        end else if (cmd_valid) begin
            unique case (op_e'(cmd_op))
                OP_EOI: begin
                    if (top_found) isr_d[top_line] = 1'b0;
                end
                OP_EOI_ROT: begin
                    if (top_found) begin
                        isr_d[top_line] = 1'b0;
                        ofs_d = top_line + W'(1);
                    end
                end
                OP_EOI_AT: isr_d[cmd_line] = 1'b0;
                OP_EOI_AT_ROT: begin
                    isr_d[cmd_line] = 1'b0;
                    ofs_d = cmd_line + W'(1);
                end
                OP_SET_BASE: ofs_d = cmd_line + W'(1);
                default: ;
            endcase
        end
    end

    // R4
    grant_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack && grant && !auto_eoi |=> isr_q[$past(grant_line)]);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack && !cmd_valid |=> $stable(isr_q) && $stable(ofs_q));

    // R8
    set_base_keeps_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack && cmd_valid && cmd_op == 3'd5 |=> $stable(isr_q));
endmodule

// File: rtl/rpr_ctrl.sv
module rpr_ctrl #(
    parameter int LINES     = 8,
    parameter int CASC_LINE = 2,
    parameter bit PRIMARY   = 1'b1,
    localparam int W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req_pend,
    input  logic [LINES-1:0] req_mask,
    input  logic             ack,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [W-1:0]     cmd_line,
    input  logic             auto_eoi,
    input  logic             auto_rot,
    input  logic             nest_special,
    output logic             irq_out,
    output logic [W-1:0]     irq_line,
    output logic [LINES-1:0] in_service,
    output logic [W-1:0]     rot_ofs
);
    logic [LINES-1:0] cand_vec, view_vec, excl;
    logic [W:0]       cand_rank, view_rank, full_rank;
    logic [W-1:0]     cand_line, full_line, unused_view_line;
    logic [LINES-1:0] isr_q;
    logic [W-1:0]     ofs_q;
    logic             grant;

    generate
        if (PRIMARY) begin : g_primary
            assign excl = nest_special ? (LINES'(1) << CASC_LINE) : '0;
        end else begin : g_secondary
            logic unused_nest;
            assign unused_nest = nest_special;
            assign excl = '0;
        end
    endgenerate

    assign cand_vec = req_pend & ~req_mask;
    assign view_vec = isr_q & ~excl;

    rpr_rank #(.LINES(LINES)) u_rank_cand (
        .vec(cand_vec), .ofs(ofs_q), .rank(cand_rank), .line(cand_line));
    rpr_rank #(.LINES(LINES)) u_rank_view (
        .vec(view_vec), .ofs(ofs_q), .rank(view_rank), .line(unused_view_line));
    rpr_rank #(.LINES(LINES)) u_rank_full (
        .vec(isr_q), .ofs(ofs_q), .rank(full_rank), .line(full_line));

    assign grant = (cand_rank != (W+1)'(LINES)) && (cand_rank < view_rank);

    rpr_state #(.LINES(LINES)) u_state (
        .clk(clk), .rst_n(rst_n), .ack(ack), .grant(grant),
        .grant_line(cand_line), .auto_eoi(auto_eoi), .auto_rot(auto_rot),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_line(cmd_line),
        .top_found(full_rank != (W+1)'(LINES)), .top_line(full_line),
        .isr_q(isr_q), .ofs_q(ofs_q));

    always_comb begin
        irq_out    = grant;
        irq_line   = grant ? cand_line : W'(LINES - 1);
        in_service = isr_q;
        rot_ofs    = ofs_q;
    end

    // R2
    offered_is_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> req_pend[irq_line] && !req_mask[irq_line]);

    // R3
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out |-> irq_line == W'(LINES - 1));
endmodule

// File: tb/rpr_ctrl_tb.sv
module rpr_ctrl_tb;
    typedef struct {
        logic       irq;
        logic [2:0] line;
        logic [7:0] isr;
        logic [2:0] ofs;
        string      tag;
    } exp_t;

    logic       clk = 0, rst_n = 0;
    logic [7:0] req_pend = 0, req_mask = 0;
    logic       ack = 0, cmd_valid = 0, auto_eoi = 0, auto_rot = 0, nest_special = 0;
    logic [2:0] cmd_op = 0, cmd_line = 0;
    logic       irq_out;
    logic [2:0] irq_line, rot_ofs;
    logic [7:0] in_service;

    int checks = 0, errors = 0;
    bit done = 0;
    exp_t q[$];
    logic [7:0] m_isr = 0;
    int m_ofs = 0;

    always #5 clk = ~clk;

    rpr_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_pend(req_pend), .req_mask(req_mask),
        .ack(ack), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_line(cmd_line),
        .auto_eoi(auto_eoi), .auto_rot(auto_rot), .nest_special(nest_special),
        .irq_out(irq_out), .irq_line(irq_line), .in_service(in_service),
        .rot_ofs(rot_ofs));

    function automatic int rank_of(logic [7:0] v, int ofs);
        for (int p = 0; p < 8; p++)
            if (v[(p + ofs) % 8]) return p;
        return 8;
    endfunction

    function automatic void offer(logic [7:0] pend, logic [7:0] mask,
                                  output logic irq, output int line);
        int rc, rv;
        rc = rank_of(pend & ~mask, m_ofs);
        rv = rank_of(m_isr & (nest_special ? 8'hFB : 8'hFF), m_ofs);
        irq  = (rc < 8) && (rc < rv);
        line = irq ? (rc + m_ofs) % 8 : 7;
    endfunction

    task automatic step(input logic [7:0] pend, input logic [7:0] mask,
                        input logic a, input logic cv, input int op,
                        input int ln, input string tag);
        logic g; int gl, r; exp_t e;
        @(negedge clk);
        offer(pend, mask, g, gl);
        if (a) begin
            if (g) begin
                if (!auto_eoi) m_isr[gl] = 1'b1;
                else if (auto_rot) m_ofs = (gl + 1) % 8;
            end
        end else if (cv) begin
            r = rank_of(m_isr, m_ofs);
            case (op)
                1: if (r < 8) m_isr[(r + m_ofs) % 8] = 1'b0;
                3: if (r < 8) begin
                       m_isr[(r + m_ofs) % 8] = 1'b0;
                       m_ofs = (r + m_ofs + 1) % 8;
                   end
                2: m_isr[ln] = 1'b0;
                4: begin m_isr[ln] = 1'b0; m_ofs = (ln + 1) % 8; end
                5: m_ofs = (ln + 1) % 8;
                default: ;
            endcase
        end
        offer(pend, mask, g, gl);
        e.irq = g; e.line = 3'(gl); e.isr = m_isr; e.ofs = 3'(m_ofs); e.tag = tag;
        q.push_back(e);
        req_pend = pend; req_mask = mask; ack = a; cmd_valid = cv;
        cmd_op = 3'(op); cmd_line = 3'(ln);
        @(posedge clk);
        #1 ack = 0; cmd_valid = 0;
    endtask

    task automatic cfg(input logic ae, input logic ar, input logic ns);
        @(negedge clk);
        auto_eoi = ae; auto_rot = ar; nest_special = ns;
    endtask

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                cmp(e.tag, "irq_out", int'(irq_out), int'(e.irq));
                cmp(e.tag, "irq_line", int'(irq_line), int'(e.line));
                cmp(e.tag, "in_service", int'(in_service), int'(e.isr));
                cmp(e.tag, "rot_ofs", int'(rot_ofs), int'(e.ofs));
            end
        end
    end

    initial begin : watchdog
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1;
        step(8'h00, 8'h00, 0, 0, 0, 0, "R1");
        step(8'h28, 8'h00, 0, 0, 0, 0, "R2");
        step(8'h28, 8'h08, 0, 0, 0, 0, "R2");
        step(8'h28, 8'h08, 1, 0, 0, 0, "R4");
        step(8'h28, 8'h00, 0, 0, 0, 0, "R3");
        step(8'h28, 8'h00, 1, 0, 0, 0, "R4");
        step(8'h28, 8'h00, 0, 1, 1, 0, "R6");
        step(8'h00, 8'h00, 0, 1, 1, 0, "R6");
        step(8'h00, 8'h00, 0, 1, 3, 0, "R6");
        step(8'h00, 8'h00, 1, 0, 0, 0, "R4");
        step(8'h28, 8'h00, 0, 1, 5, 4, "R8");
        step(8'h28, 8'h00, 1, 0, 0, 0, "R4");
        step(8'h28, 8'h00, 0, 1, 3, 0, "R6");
        step(8'h04, 8'h00, 1, 0, 0, 0, "R4");
        step(8'h04, 8'h00, 0, 0, 0, 0, "R3");
        cfg(0, 0, 1);
        step(8'h04, 8'h00, 0, 0, 0, 0, "R9");
        step(8'h04, 8'h00, 0, 1, 1, 0, "R9");
        cfg(0, 0, 0);
        step(8'h80, 8'h00, 1, 0, 0, 0, "R4");
        step(8'h80, 8'h00, 0, 1, 4, 7, "R7");
        step(8'h02, 8'h00, 1, 0, 0, 0, "R4");
        step(8'h00, 8'h00, 0, 1, 2, 1, "R7");
        step(8'h10, 8'h00, 1, 1, 5, 0, "R10");
        step(8'h00, 8'h00, 0, 1, 6, 2, "R10");
        step(8'h00, 8'h00, 0, 1, 7, 4, "R10");
        step(8'h00, 8'h00, 0, 1, 0, 4, "R10");
        cfg(1, 0, 0);
        step(8'h01, 8'h00, 1, 0, 0, 0, "R5");
        cfg(1, 1, 0);
        step(8'h40, 8'h00, 1, 0, 0, 0, "R5");
        cfg(0, 0, 0);
        step(8'h00, 8'h00, 0, 1, 2, 4, "R7");
        for (int i = 0; i < 400; i++) begin
            if (i % 50 == 0) cfg(1'($urandom), 1'($urandom), 1'($urandom));
            step(8'($urandom), 8'($urandom) & 8'($urandom), 1'($urandom % 3 == 0),
                 1'($urandom), int'($urandom % 8), int'($urandom % 8), "R2");
        end
        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule